// File: doc/BRIEF.md
# ATA PIO Register Access Sequencer

This block runs single programmed-I/O register cycles on a parallel ATA device bus. A host presents one request at a time: a 5-bit register code, a read/write flag, a device select and a 16-bit write value. The sequencer takes the request when it is idle and drives the chip selects, the three device address lines, the read or write strobe and the data bus. It keeps to the setup, strobe-active and recovery times that belong to the PIO mode in force. After recovery it raises a one-cycle completion pulse. For reads, the data captured when the strobe was released is valid alongside that pulse.

Each of the two attached devices has its own PIO mode, 0 to 4. Accesses to the 16-bit data register use the mode of the addressed device. Every other taskfile or control register is shared by both devices, so those accesses use the slower of the two modes whenever a second device is present. The strobe is held low until the device's ready line, after a synchronizer, reads high. A programmable limit ends that wait and flags an error.

Top module: `ata_pio_seq`

## Requirements
- R1: The register code is decoded as follows during the whole cycle: bits [2:0] drive `da_o`, bit 3 drives `cs0_n_o` and bit 4 drives `cs1_n_o`. For example, code 0x17 gives cs0_n=0, cs1_n=1, da=7, and code 0x0E gives cs0_n=1, cs1_n=0, da=6. These outputs stay stable while busy.
- R2: After reset and whenever idle, `cs0_n_o`, `cs1_n_o`, `dior_n_o` and `diow_n_o` are all 1, and `busy_o`, `done_o` and `dd_oe_o` are 0.
- R3: A read keeps both strobes high for the mode's setup count of cycles. It then holds `dior_n_o` low for the active count plus one cycle when IORDY is already high, and waits the recovery count of cycles. `done_o` then pulses, and `rd_data_o` holds the bus value sampled at strobe release. `diow_n_o` stays high throughout.
- R4: A write follows the same setup/active/recovery sequence on `diow_n_o`, with `dior_n_o` held high. `dd_oe_o` is 1 and `dd_o` carries the write value while the strobe is low.
- R5: The default cycle counts for modes 0..4 are: setup 18/13/8/8/7, active 42/32/25/20/18, recovery 92/52/28/18/7. A mode value above 4 is treated as mode 0.
- R6: Code 0x10, the data register, uses the addressed device's mode. Any other code uses the lower-numbered (slower) of the two device modes when `dev1_present_i` is 1, and the addressed device's mode otherwise.
- R7: `wait_states_o` is 3 for an effective mode of 0, 2 for modes 1 and 2, and 1 for modes 3 and 4. It is updated when a request is accepted and is 3 after reset.
- R8: The strobe stays low until the two-flop synchronized IORDY is high. If IORDY rises in the k-th low cycle, and k is past the active count, the strobe is low for exactly k+2 cycles and no error is flagged.
- R9: If synchronized IORDY stays low for `iordy_limit_i`+1 wait cycles, the strobe is released anyway. The strobe is then low for the active count plus `iordy_limit_i`+1 cycles, recovery still runs, and `err_o` is 1 when `done_o` pulses. `err_o` clears at the next accepted request.
- R10: For any code other than 0x10, read data returns with bits [15:8] zero and write data is driven with bits [15:8] zero. The data register passes all 16 bits.
- R11: `req_ack_o` is 1 only when `req_valid_i` is 1 and the sequencer is idle. `busy_o` is 1 from the accepting edge until recovery ends. `done_o` is a single-cycle pulse in the first idle cycle. A request held during a cycle is not acknowledged until that cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_dev_i | input | 1 | Addressed device (0 or 1) |
| req_addr_i | input | 5 | Register code: {cs1_n, cs0_n, address[2:0]} |
| req_wdata_i | input | 16 | Write value |
| req_ack_o | output | 1 | Request taken this cycle |
| dev0_mode_i | input | 3 | PIO mode of device 0 |
| dev1_mode_i | input | 3 | PIO mode of device 1 |
| dev1_present_i | input | 1 | Second device attached |
| iordy_limit_i | input | 12 | Maximum wait cycles for IORDY |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | Cycle finished (one-cycle pulse) |
| err_o | output | 1 | Last cycle ended by IORDY timeout |
| rd_data_o | output | 16 | Read result |
| wait_states_o | output | 2 | Wait-state count for the effective mode |
| cs0_n_o | output | 1 | Chip select 0, active low |
| cs1_n_o | output | 1 | Chip select 1, active low |
| da_o | output | 3 | Device address |
| dior_n_o | output | 1 | Read strobe, active low |
| diow_n_o | output | 1 | Write strobe, active low |
| dd_o | output | 16 | Data bus out |
| dd_oe_o | output | 1 | Data bus output enable |
| dd_i | input | 16 | Data bus in |
| iordy_i | input | 1 | Device ready (asynchronous) |

## Verification
The hardest situation to reach is IORDY rising part-way through the wait phase. In that case the strobe length depends on the synchronizer latency, not on the timing table alone. The stimulus holds IORDY low before the request, counts low-strobe cycles at the falling clock edge, and raises IORDY at a chosen count well past the active time, so the expected k+2 length is exact. Timeout is reached the same way with IORDY never released and a small limit. A follow-up cycle then shows the error flag clearing.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int unsigned NUM_MODES = 5;
  localparam logic [4:0]  DATA_REG_CODE = 5'h10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_WAIT,
    ST_RECOV
  } seq_state_t;

  // Modes beyond the supported range fall back to the slowest one
  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    return (m > 3'd4) ? 3'd0 : m;
  endfunction

  function automatic logic [1:0] wait_states(input logic [2:0] m);
    logic [1:0] ws;
    case (norm_mode(m))
      3'd0:       ws = 2'd3;
      3'd1, 3'd2: ws = 2'd2;
      default:    ws = 2'd1;
    endcase
    return ws;
  endfunction

endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  generate
    if (STAGES < 2) begin : g_single
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= d_i;
      end
      assign q_o = s_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ata_pio_mode_pick.sv
module ata_pio_mode_pick
  import ata_pio_pkg::*;
(
  input  logic [2:0] dev0_mode_i,
  input  logic [2:0] dev1_mode_i,
  input  logic       dev1_present_i,
  input  logic       dev_sel_i,
  input  logic [4:0] addr_i,
  output logic [2:0] mode_o
);

  logic [2:0] m0, m1, own, slow, shared;

  always_comb begin
    m0     = norm_mode(dev0_mode_i);
    m1     = norm_mode(dev1_mode_i);
    own    = dev_sel_i ? m1 : m0;
    slow   = (m0 < m1) ? m0 : m1;
    shared = dev1_present_i ? slow : own;
    mode_o = (addr_i == DATA_REG_CODE) ? own : shared;
  end

endmodule

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned SETUP_CYC  [NUM_MODES] = '{18, 13, 8, 8, 7},
  parameter int unsigned ACTIVE_CYC [NUM_MODES] = '{42, 32, 25, 20, 18},
  parameter int unsigned RECOV_CYC  [NUM_MODES] = '{92, 52, 28, 18, 7}
) (
  input  logic [2:0]    mode_i,
  output logic [CW-1:0] setup_o,
  output logic [CW-1:0] active_o,
  output logic [CW-1:0] recov_o
);

  logic [CW-1:0] tbl_setup  [NUM_MODES];
  logic [CW-1:0] tbl_active [NUM_MODES];
  logic [CW-1:0] tbl_recov  [NUM_MODES];

  // A zero count would underflow the phase counter; clamp to one cycle
  generate
    for (genvar g = 0; g < NUM_MODES; g++) begin : g_tbl
      assign tbl_setup[g]  = CW'((SETUP_CYC[g]  == 0) ? 1 : SETUP_CYC[g]);
      assign tbl_active[g] = CW'((ACTIVE_CYC[g] == 0) ? 1 : ACTIVE_CYC[g]);
      assign tbl_recov[g]  = CW'((RECOV_CYC[g]  == 0) ? 1 : RECOV_CYC[g]);
    end
  endgenerate

  always_comb begin
    setup_o  = tbl_setup[0];
    active_o = tbl_active[0];
    recov_o  = tbl_recov[0];
    for (int i = 0; i < NUM_MODES; i++) begin
      if (mode_i == 3'(i)) begin
        setup_o  = tbl_setup[i];
        active_o = tbl_active[i];
        recov_o  = tbl_recov[i];
      end
    end
  end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int unsigned CW          = 8,
  parameter int unsigned TOW         = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETUP_CYC  [NUM_MODES] = '{18, 13, 8, 8, 7},
  parameter int unsigned ACTIVE_CYC [NUM_MODES] = '{42, 32, 25, 20, 18},
  parameter int unsigned RECOV_CYC  [NUM_MODES] = '{92, 52, 28, 18, 7}
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid_i,
  input  logic           req_write_i,
  input  logic           req_dev_i,
  input  logic [4:0]     req_addr_i,
  input  logic [15:0]    req_wdata_i,
  output logic           req_ack_o,
  input  logic [2:0]     dev0_mode_i,
  input  logic [2:0]     dev1_mode_i,
  input  logic           dev1_present_i,
  input  logic [TOW-1:0] iordy_limit_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_o,
  output logic [15:0]    rd_data_o,
  output logic [1:0]     wait_states_o,
  output logic           cs0_n_o,
  output logic           cs1_n_o,
  output logic [2:0]     da_o,
  output logic           dior_n_o,
  output logic           diow_n_o,
  output logic [15:0]    dd_o,
  output logic           dd_oe_o,
  input  logic [15:0]    dd_i,
  input  logic           iordy_i
);

  seq_state_t     state_q, state_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [TOW-1:0] wcnt_q, wcnt_d;
  logic [4:0]     addr_q, addr_d;
  logic           write_q, write_d;
  logic [15:0]    wdata_q, wdata_d;
  logic [2:0]     mode_q, mode_d;
  logic [15:0]    rdata_q, rdata_d;
  logic           err_q, err_d;
  logic           done_q, done_d;
  logic [1:0]     ws_q, ws_d;
  logic           cs0_n_q, cs0_n_d, cs1_n_q, cs1_n_d;
  logic [2:0]     da_q, da_d;
  logic           dior_n_q, dior_n_d, diow_n_q, diow_n_d;
  logic           oe_q, oe_d;

  logic           accept;
  logic           iordy_s;
  logic [2:0]     req_mode;
  logic [CW-1:0]  setup_len, active_len, recov_len;
  logic           req_is_data, cur_is_data;
  logic           strobe_phase_d;

  ata_pio_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (iordy_i),
    .q_o   (iordy_s)
  );

  ata_pio_mode_pick u_pick (
    .dev0_mode_i    (dev0_mode_i),
    .dev1_mode_i    (dev1_mode_i),
    .dev1_present_i (dev1_present_i),
    .dev_sel_i      (req_dev_i),
    .addr_i         (req_addr_i),
    .mode_o         (req_mode)
  );

  ata_pio_timing #(
    .CW         (CW),
    .SETUP_CYC  (SETUP_CYC),
    .ACTIVE_CYC (ACTIVE_CYC),
    .RECOV_CYC  (RECOV_CYC)
  ) u_timing (
    .mode_i   (mode_q),
    .setup_o  (setup_len),
    .active_o (active_len),
    .recov_o  (recov_len)
  );

  assign accept      = req_valid_i && (state_q == ST_IDLE);
  assign req_is_data = (req_addr_i == DATA_REG_CODE);
  assign cur_is_data = (addr_q == DATA_REG_CODE);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wcnt_d  = wcnt_q;
    addr_d  = addr_q;
    write_d = write_q;
    wdata_d = wdata_q;
    mode_d  = mode_q;
    rdata_d = rdata_q;
    err_d   = err_q;
    ws_d    = ws_q;
    done_d  = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SETUP;
          cnt_d   = '0;
          addr_d  = req_addr_i;
          write_d = req_write_i;
          wdata_d = req_is_data ? req_wdata_i : {8'h00, req_wdata_i[7:0]};
          mode_d  = req_mode;
          ws_d    = wait_states(req_mode);
          err_d   = 1'b0;
        end
      end
      ST_SETUP: begin
        if (cnt_q == setup_len - 1'b1) begin
          state_d = ST_ACTIVE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (cnt_q == active_len - 1'b1) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
          wcnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (iordy_s || (wcnt_q == iordy_limit_i)) begin
          state_d = ST_RECOV;
          err_d   = !iordy_s;
          rdata_d = cur_is_data ? dd_i : {8'h00, dd_i[7:0]};
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt_q == recov_len - 1'b1) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Bus pin next values, registered so strobes never glitch
  always_comb begin
    strobe_phase_d = (state_d == ST_ACTIVE) || (state_d == ST_WAIT);
    if (state_d == ST_IDLE) begin
      cs0_n_d = 1'b1;
      cs1_n_d = 1'b1;
      da_d    = 3'd0;
    end else begin
      cs0_n_d = addr_d[3];
      cs1_n_d = addr_d[4];
      da_d    = addr_d[2:0];
    end
    dior_n_d = !(strobe_phase_d && !write_d);
    diow_n_d = !(strobe_phase_d && write_d);
    oe_d     = write_d && (strobe_phase_d || (state_d == ST_RECOV));
  end

  // Control and pin registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      wcnt_q   <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cs0_n_q  <= 1'b1;
      cs1_n_q  <= 1'b1;
      da_q     <= 3'd0;
      dior_n_q <= 1'b1;
      diow_n_q <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      wcnt_q   <= wcnt_d;
      done_q   <= done_d;
      err_q    <= err_d;
      cs0_n_q  <= cs0_n_d;
      cs1_n_q  <= cs1_n_d;
      da_q     <= da_d;
      dior_n_q <= dior_n_d;
      diow_n_q <= diow_n_d;
      oe_q     <= oe_d;
    end
  end

  // Request capture, enabled on accept only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= 5'd0;
      write_q <= 1'b0;
      wdata_q <= 16'd0;
      mode_q  <= 3'd0;
      ws_q    <= 2'd3;
    end else if (accept) begin
      addr_q  <= addr_d;
      write_q <= write_d;
      wdata_q <= wdata_d;
      mode_q  <= mode_d;
      ws_q    <= ws_d;
    end
  end

  // Read data capture, enabled at strobe release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= 16'd0;
    end else if ((state_q == ST_WAIT) && (state_d == ST_RECOV)) begin
      rdata_q <= rdata_d;
    end
  end

  assign req_ack_o     = accept;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign rd_data_o     = rdata_q;
  assign wait_states_o = ws_q;
  assign cs0_n_o       = cs0_n_q;
  assign cs1_n_o       = cs1_n_q;
  assign da_o          = da_q;
  assign dior_n_o      = dior_n_q;
  assign diow_n_o      = diow_n_q;
  assign dd_o          = wdata_q;
  assign dd_oe_o       = oe_q;

  // Assertions
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cs0_n_o && cs1_n_o && dior_n_o && diow_n_o && !dd_oe_o));

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dior_n_o || diow_n_o));

  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(da_o) && $stable(cs0_n_o) && $stable(cs1_n_o)));

  p_release_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dior_n_o) || $rose(diow_n_o)) |-> ($past(iordy_s) || err_o));

  p_done_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_ack_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack_o |=> (busy_o && !done_o));

endmodule

// File: tb/ata_pio_seq_tb.sv
`timescale 1ns/1ps
module ata_pio_seq_tb_top;

  localparam int ES [5] = '{18, 13, 8, 8, 7};
  localparam int EA [5] = '{42, 32, 25, 20, 18};
  localparam int ER [5] = '{92, 52, 28, 18, 7};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_dev = 1'b0;
  logic [4:0]  req_addr = 5'd0;
  logic [15:0] req_wdata = 16'd0;
  logic        req_ack;
  logic [2:0]  dev0_mode = 3'd0, dev1_mode = 3'd0;
  logic        dev1_present = 1'b0;
  logic [11:0] iordy_limit = 12'd200;
  logic        busy, done, err;
  logic [15:0] rd_data;
  logic [1:0]  ws;
  logic        cs0_n, cs1_n, dior_n, diow_n, dd_oe;
  logic [2:0]  da;
  logic [15:0] dd_out;
  logic [15:0] dd_in = 16'd0;
  logic        iordy = 1'b1;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // Per-cycle measurements
  int m_setup, m_low, m_recov, m_ack_busy, m_rd_strobe, m_wr_strobe;
  logic m_cs0, m_cs1, m_unstable, m_done, m_done_after, m_err, m_oe;
  logic [2:0]  m_da;
  logic [1:0]  m_ws;
  logic [15:0] m_rd, m_dd;

  always #2 clk = ~clk;

  ata_pio_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_dev_i(req_dev),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ack_o(req_ack),
    .dev0_mode_i(dev0_mode), .dev1_mode_i(dev1_mode), .dev1_present_i(dev1_present),
    .iordy_limit_i(iordy_limit),
    .busy_o(busy), .done_o(done), .err_o(err), .rd_data_o(rd_data), .wait_states_o(ws),
    .cs0_n_o(cs0_n), .cs1_n_o(cs1_n), .da_o(da), .dior_n_o(dior_n), .diow_n_o(diow_n),
    .dd_o(dd_out), .dd_oe_o(dd_oe), .dd_i(dd_in), .iordy_i(iordy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Issue one request, then sample every cycle at the falling edge until idle
  task automatic run_cycle(input logic wr, input logic dev, input logic [4:0] addr,
                           input logic [15:0] wd, input int rel_at, input bit hold);
    int guard;
    bit seen_low;
    req_write = wr; req_dev = dev; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    guard = 0;
    while (!req_ack && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = hold;
    m_setup = 0; m_low = 0; m_recov = 0; m_ack_busy = 0; m_rd_strobe = 0; m_wr_strobe = 0;
    m_cs0 = cs0_n; m_cs1 = cs1_n; m_da = da; m_ws = ws; m_unstable = 0;
    m_dd = 16'd0; m_oe = 0;
    seen_low = 0;
    guard = 0;
    while (busy && guard < 5000) begin
      if (req_ack) m_ack_busy++;
      if (!dior_n || !diow_n) begin
        seen_low = 1;
        m_low++;
        if (!dior_n) m_rd_strobe++;
        if (!diow_n) m_wr_strobe++;
        m_dd = dd_out; m_oe = dd_oe;
        if (rel_at != 0 && m_low == rel_at) iordy = 1'b1;
      end else if (!seen_low) m_setup++;
      else m_recov++;
      if (cs0_n != m_cs0 || cs1_n != m_cs1 || da != m_da) m_unstable = 1;
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b0;
    m_done = done; m_rd = rd_data; m_err = err;
    @(negedge clk);
    m_done_after = done;
  endtask

  task automatic t_reset;
    check("R2", "cs0_n idle", cs0_n, 1);
    check("R2", "cs1_n idle", cs1_n, 1);
    check("R2", "dior_n idle", dior_n, 1);
    check("R2", "diow_n idle", diow_n, 1);
    check("R2", "busy idle", busy, 0);
    check("R2", "done idle", done, 0);
    check("R2", "dd_oe idle", dd_oe, 0);
    check("R7", "wait states after reset", ws, 3);
  endtask

  task automatic t_read_status;
    dev0_mode = 3'd4; dev1_present = 1'b0; iordy = 1'b1; dd_in = 16'hA55A;
    run_cycle(1'b0, 1'b0, 5'h17, 16'h0, 0, 0);
    check("R1", "cs0_n for 0x17", m_cs0, 0);
    check("R1", "cs1_n for 0x17", m_cs1, 1);
    check("R1", "da for 0x17", m_da, 7);
    check("R1", "address stable", m_unstable, 0);
    check("R3", "read setup", m_setup, ES[4]);
    check("R3", "read strobe low", m_rd_strobe, EA[4] + 1);
    check("R3", "write strobe idle in read", m_wr_strobe, 0);
    check("R3", "read recovery", m_recov, ER[4]);
    check("R3", "done at end", m_done, 1);
    check("R10", "status byte read", m_rd, 16'h005A);
    check("R7", "wait states mode 4", m_ws, 1);
    check("R2", "quiet after cycle", {cs0_n, cs1_n, dior_n, diow_n}, 4'hF);
  endtask

  task automatic t_write_data;
    dev0_mode = 3'd0;
    run_cycle(1'b1, 1'b0, 5'h10, 16'hBEEF, 0, 0);
    check("R4", "write setup", m_setup, ES[0]);
    check("R4", "write strobe low", m_wr_strobe, EA[0] + 1);
    check("R4", "read strobe idle in write", m_rd_strobe, 0);
    check("R4", "write recovery", m_recov, ER[0]);
    check("R4", "oe during strobe", m_oe, 1);
    check("R10", "data reg full word", m_dd, 16'hBEEF);
    check("R1", "cs0_n for 0x10", m_cs0, 0);
    check("R1", "cs1_n for 0x10", m_cs1, 1);
    check("R7", "wait states mode 0", m_ws, 3);
    check("R4", "oe off when idle", dd_oe, 0);
  endtask

  task automatic t_write_ctrl;
    dev0_mode = 3'd2;
    run_cycle(1'b1, 1'b0, 5'h0E, 16'h1234, 0, 0);
    check("R1", "cs0_n for 0x0E", m_cs0, 1);
    check("R1", "cs1_n for 0x0E", m_cs1, 0);
    check("R1", "da for 0x0E", m_da, 6);
    check("R10", "control byte write", m_dd, 16'h0034);
    check("R5", "mode 2 setup", m_setup, ES[2]);
    check("R7", "wait states mode 2", m_ws, 2);
  endtask

  task automatic t_pairing;
    dev0_mode = 3'd4; dev1_mode = 3'd1; dev1_present = 1'b1; dd_in = 16'hC3E1;
    run_cycle(1'b0, 1'b0, 5'h17, 16'h0, 0, 0);
    check("R6", "shared reg uses slower mode", m_setup, ES[1]);
    check("R6", "shared reg active", m_rd_strobe, EA[1] + 1);
    check("R7", "wait states mode 1", m_ws, 2);
    run_cycle(1'b0, 1'b0, 5'h10, 16'h0, 0, 0);
    check("R6", "data reg uses own mode", m_setup, ES[4]);
    check("R10", "data reg full read", m_rd, 16'hC3E1);
    dev1_present = 1'b0;
    run_cycle(1'b0, 1'b0, 5'h17, 16'h0, 0, 0);
    check("R6", "no second device", m_setup, ES[4]);
    dev1_present = 1'b1;
    run_cycle(1'b0, 1'b1, 5'h10, 16'h0, 0, 0);
    check("R6", "data reg on device 1", m_setup, ES[1]);
    dev1_present = 1'b0;
  endtask

  task automatic t_bad_mode;
    dev0_mode = 3'd6;
    run_cycle(1'b0, 1'b0, 5'h11, 16'h0, 0, 0);
    check("R5", "mode 6 setup as mode 0", m_setup, ES[0]);
    check("R5", "mode 6 recovery as mode 0", m_recov, ER[0]);
    check("R7", "mode 6 wait states", m_ws, 3);
  endtask

  task automatic t_iordy_late;
    dev0_mode = 3'd4; iordy_limit = 12'd100; iordy = 1'b0;
    run_cycle(1'b0, 1'b0, 5'h12, 16'h0, EA[4] + 5, 0);
    check("R8", "strobe held for IORDY", m_low, EA[4] + 7);
    check("R8", "no error on late IORDY", m_err, 0);
    check("R8", "done on late IORDY", m_done, 1);
  endtask

  task automatic t_timeout;
    dev0_mode = 3'd3; iordy_limit = 12'd5; iordy = 1'b0;
    run_cycle(1'b1, 1'b0, 5'h13, 16'h00AA, 0, 0);
    check("R9", "strobe low to timeout", m_low, EA[3] + 6);
    check("R9", "error flagged", m_err, 1);
    check("R9", "recovery after timeout", m_recov, ER[3]);
    check("R9", "done after timeout", m_done, 1);
    iordy = 1'b1;
    repeat (3) @(negedge clk);
    run_cycle(1'b1, 1'b0, 5'h13, 16'h00AA, 0, 0);
    check("R9", "error cleared next cycle", m_err, 0);
    iordy_limit = 12'd200;
  endtask

  task automatic t_handshake;
    dev0_mode = 3'd4;
    check("R11", "no ack without request", req_ack, 0);
    run_cycle(1'b0, 1'b0, 5'h17, 16'h0, 0, 1);
    check("R11", "no ack while busy", m_ack_busy, 0);
    check("R11", "done pulse", m_done, 1);
    check("R11", "done single cycle", m_done_after, 0);
    check("R11", "busy low after cycle", busy, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_status();
    t_write_data();
    t_write_ctrl();
    t_pairing();
    t_bad_mode();
    t_iordy_late();
    t_timeout();
    t_handshake();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule